// File: doc/BRIEF.md
# Programmable Packet Transmit Framer

This block turns a buffered payload into a serial packet. Every frame carries, in fixed order, an alternating preamble, a sync word, an alternating trailer, the payload bytes taken from a small local byte buffer, and an optional 16-bit CRC. Each field length is set by configuration inputs. The frame comes out as one NRZ bit per clock, with a strobe that marks valid bits. A one-cycle completion pulse follows the last bit.

Software first clears the buffer's write pointer and then writes the payload bytes. It sets the configuration and pulses `start`. The framer captures the configuration at that moment. The buffer's read pointer is forced back to entry zero as the last sync bit leaves, so the payload always starts at entry zero. The same buffered payload can therefore be sent again without reloading it.

Top module: `pkt_tx_framer`

## Requirements
- R1: While and right after reset, `tx_valid` and `done` are low.
- R2: The preamble lasts (`cfg_pre_bytes`+1)×8 bits. Preamble bit k (k counted from 0) equals the first sync bit XOR (k mod 2). The last preamble bit is therefore the inverse of the first sync bit.
- R3: The sync length is selected by `cfg_sync_sel`: 0 gives 32 bits, 1 gives 48 bits, 2 or 3 gives 64 bits. For length L, bits `cfg_sync_word[L-1]` down to `cfg_sync_word[0]` are sent, most significant first.
- R4: The trailer length is `cfg_trl_bits`+1 bits, with a minimum of 4 bits (values 0 to 2 give 4 bits). Trailer bit j equals the inverse of `cfg_sync_word[0]` XOR (j mod 2).
- R5: After the trailer, `cfg_pay_len` payload bytes are sent, most significant bit first. They are read from buffer entries 0, 1, 2 and so on. A length of 0 sends no payload field.
- R6: The read pointer is zeroed when the last sync bit is sent. A later frame therefore resends the same buffered bytes from entry 0 without any new writes.
- R7: When `cfg_crc_en` is 1, 16 CRC bits follow the payload, most significant bit first. The CRC uses polynomial 0x1021, starts at 0xFFFF, and covers only the payload bits in transmit order. When `cfg_crc_en` is 0, no CRC is sent.
- R8: `tx_valid` rises in the cycle after `start` is sampled while the framer is idle. It stays high for exactly the frame's bit count.
- R9: `done` is high for exactly one cycle. That cycle is the first cycle after the last bit, and `tx_valid` is low in it.
- R10: A `start` pulse during a frame is ignored. Configuration changes during a frame do not alter that frame.
- R11: `wr_clr` zeroes the write pointer, and the next write lands in entry 0. When `wr_clr` and `wr_en` are high in the same cycle, the write is dropped.
- R12: The buffer addresses wrap modulo `DEPTH`. A payload longer than `DEPTH` bytes repeats entries from entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame when idle |
| cfg_pre_bytes | input | 3 | Preamble bytes minus one |
| cfg_sync_sel | input | 2 | Sync length select |
| cfg_sync_word | input | 64 | Sync word value |
| cfg_trl_bits | input | 4 | Trailer bits minus one (minimum 4 bits) |
| cfg_pay_len | input | LEN_W | Payload byte count |
| cfg_crc_en | input | 1 | Append CRC |
| wr_clr | input | 1 | Clear buffer write pointer |
| wr_en | input | 1 | Write one payload byte |
| wr_data | input | 8 | Payload byte |
| tx_bit | output | 1 | Serial frame bit |
| tx_valid | output | 1 | Bit strobe |
| done | output | 1 | Frame-complete pulse |

## Verification
The hardest case to reach from the ports is the read-pointer re-zeroing. A single frame cannot show it, because a fresh buffer also starts at zero. The bench therefore sends many frames back to back without reloading the buffer, and it runs payloads longer than the buffer depth. Any pointer that is not cleared at the end of the sync word shifts the payload of every later frame. A second hard case is a start pulse and a configuration change injected in the middle of a frame. The bench then checks that the frame bits match the configuration captured at start.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SYNC = 3'd2,
    ST_TRL  = 3'd3,
    ST_PAY  = 3'd4,
    ST_CRC  = 3'd5
  } ptf_state_e;

  // Sync field length in bits from the select code.
  function automatic logic [6:0] sync_bits(input logic [1:0] sel);
    case (sel)
      2'd0:    sync_bits = 7'd32;
      2'd1:    sync_bits = 7'd48;
      default: sync_bits = 7'd64;
    endcase
  endfunction

  // Trailer length: code plus one, never below four.
  function automatic logic [4:0] trl_bits(input logic [3:0] code);
    if (code < 4'd3) trl_bits = 5'd4;
    else             trl_bits = {1'b0, code} + 5'd1;
  endfunction

  // One serial step of the 0x1021 CRC.
  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    crc_step = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
  endfunction

endpackage

// File: rtl/ptf_fifo.sv
module ptf_fifo #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_clr,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          rd_zero,
  input  logic          rd_adv,
  output logic [7:0]    rd_data,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && !wr_clr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wr_ptr <= '0;
    else if (wr_clr) wr_ptr <= '0;
    else if (wr_en)  wr_ptr <= wr_ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_ptr <= '0;
    else if (rd_zero) rd_ptr <= '0;
    else if (rd_adv)  rd_ptr <= rd_ptr + 1'b1;
  end

  assign rd_data = mem[rd_ptr];

endmodule

// File: rtl/ptf_crc16.sv
module ptf_crc16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc
);
  import ptf_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= 16'hFFFF;
    else if (init) crc <= 16'hFFFF;
    else if (en)   crc <= crc_step(crc, din);
  end

endmodule

// File: rtl/ptf_seq.sv
module ptf_seq #(
  parameter int LEN_W = 8,
  parameter int CNT_W = LEN_W + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [2:0]           cfg_pre_bytes,
  input  logic [1:0]           cfg_sync_sel,
  input  logic [63:0]          cfg_sync_word,
  input  logic [3:0]           cfg_trl_bits,
  input  logic [LEN_W-1:0]     cfg_pay_len,
  input  logic                 cfg_crc_en,
  input  logic [7:0]           pay_byte,
  input  logic [15:0]          crc_val,
  output logic                 tx_bit,
  output logic                 tx_valid,
  output logic                 done,
  output ptf_pkg::ptf_state_e  state,
  output logic                 frame_go,
  output logic                 sync_done,
  output logic                 byte_done,
  output logic                 pay_active
);
  import ptf_pkg::*;

  logic [2:0]       pre_q;
  logic [1:0]       sel_q;
  logic [63:0]      sw_q;
  logic [3:0]       trl_q;
  logic [LEN_W-1:0] len_q;
  logic             crc_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] field_len;
  logic [6:0]       slen;
  logic [6:0]       sidx;
  logic             last;
  ptf_state_e       nxt;

  assign frame_go = start && (state == ST_IDLE);
  assign slen     = sync_bits(sel_q);
  assign sidx     = slen - 7'd1 - cnt[6:0];

  always_comb begin
    case (state)
      ST_PRE:  field_len = CNT_W'({pre_q, 3'b000}) + CNT_W'(8);
      ST_SYNC: field_len = CNT_W'(slen);
      ST_TRL:  field_len = CNT_W'(trl_bits(trl_q));
      ST_PAY:  field_len = CNT_W'({len_q, 3'b000});
      ST_CRC:  field_len = CNT_W'(16);
      default: field_len = CNT_W'(1);
    endcase
  end

  assign last = (state != ST_IDLE) && (cnt == field_len - CNT_W'(1));

  // Field order: preamble, sync, trailer, payload, crc.
  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start) nxt = ST_PRE;
      ST_PRE:  if (last) nxt = ST_SYNC;
      ST_SYNC: if (last) nxt = ST_TRL;
      ST_TRL:  if (last) nxt = (len_q != '0) ? ST_PAY : (crc_q ? ST_CRC : ST_IDLE);
      ST_PAY:  if (last) nxt = crc_q ? ST_CRC : ST_IDLE;
      ST_CRC:  if (last) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= last && (nxt == ST_IDLE);
      if (last || state == ST_IDLE) cnt <= '0;
      else                          cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sel_q <= '0;
      sw_q  <= '0;
      trl_q <= '0;
      len_q <= '0;
      crc_q <= 1'b0;
    end else if (frame_go) begin
      pre_q <= cfg_pre_bytes;
      sel_q <= cfg_sync_sel;
      sw_q  <= cfg_sync_word;
      trl_q <= cfg_trl_bits;
      len_q <= cfg_pay_len;
      crc_q <= cfg_crc_en;
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  tx_bit = sw_q[6'(slen - 7'd1)] ^ cnt[0];
      ST_SYNC: tx_bit = sw_q[sidx[5:0]];
      ST_TRL:  tx_bit = ~sw_q[0] ^ cnt[0];
      ST_PAY:  tx_bit = pay_byte[3'd7 - cnt[2:0]];
      ST_CRC:  tx_bit = crc_val[4'd15 - cnt[3:0]];
      default: tx_bit = 1'b0;
    endcase
  end

  assign tx_valid   = (state != ST_IDLE);
  assign sync_done  = (state == ST_SYNC) && last;
  assign pay_active = (state == ST_PAY);
  assign byte_done  = pay_active && (cnt[2:0] == 3'd7);

endmodule

// File: rtl/pkt_tx_framer.sv
module pkt_tx_framer #(
  parameter int DEPTH = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       cfg_pre_bytes,
  input  logic [1:0]       cfg_sync_sel,
  input  logic [63:0]      cfg_sync_word,
  input  logic [3:0]       cfg_trl_bits,
  input  logic [LEN_W-1:0] cfg_pay_len,
  input  logic             cfg_crc_en,
  input  logic             wr_clr,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             tx_bit,
  output logic             tx_valid,
  output logic             done
);
  import ptf_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = LEN_W + 3;

  logic [7:0]    pay_byte;
  logic [15:0]   crc_val;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  ptf_state_e    fsm_state;
  logic          frame_go;
  logic          sync_done;
  logic          byte_done;
  logic          pay_active;

  ptf_fifo #(.DEPTH(DEPTH), .AW(AW)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_clr  (wr_clr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_zero (sync_done),
    .rd_adv  (byte_done),
    .rd_data (pay_byte),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr)
  );

  ptf_crc16 crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (frame_go),
    .en    (pay_active),
    .din   (tx_bit),
    .crc   (crc_val)
  );

  ptf_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_pre_bytes (cfg_pre_bytes),
    .cfg_sync_sel  (cfg_sync_sel),
    .cfg_sync_word (cfg_sync_word),
    .cfg_trl_bits  (cfg_trl_bits),
    .cfg_pay_len   (cfg_pay_len),
    .cfg_crc_en    (cfg_crc_en),
    .pay_byte      (pay_byte),
    .crc_val       (crc_val),
    .tx_bit        (tx_bit),
    .tx_valid      (tx_valid),
    .done          (done),
    .state         (fsm_state),
    .frame_go      (frame_go),
    .sync_done     (sync_done),
    .byte_done     (byte_done),
    .pay_active    (pay_active)
  );

endmodule

// File: rtl/ptf_checker.sv
module ptf_checker #(
  parameter int AW = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tx_bit,
  input logic                tx_valid,
  input logic                done,
  input logic                wr_clr,
  input logic                sync_done,
  input logic [AW-1:0]       wr_ptr,
  input logic [AW-1:0]       rd_ptr,
  input ptf_pkg::ptf_state_e fsm_state
);
  import ptf_pkg::*;

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_valid); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_PRE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_PRE && $past(fsm_state) == ST_PRE) |-> (tx_bit != $past(tx_bit))); // R2
  AST_PRE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_SYNC && $past(fsm_state) != ST_SYNC) |-> ($past(fsm_state) == ST_PRE && tx_bit != $past(tx_bit))); // R2
  AST_TRL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_TRL && $past(fsm_state) != ST_TRL) |-> ($past(fsm_state) == ST_SYNC && tx_bit != $past(tx_bit))); // R4
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sync_done |=> (rd_ptr == '0)); // R6
  AST_WR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (wr_ptr == '0)); // R11
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == ST_PRE && $past(fsm_state) != ST_IDLE) |-> $past(fsm_state) == ST_PRE); // R10

endmodule

bind pkt_tx_framer ptf_checker #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_bit    (tx_bit),
  .tx_valid  (tx_valid),
  .done      (done),
  .wr_clr    (wr_clr),
  .sync_done (sync_done),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .fsm_state (fsm_state)
);

// File: tb/pkt_tx_framer_tb_top.sv
module pkt_tx_framer_tb_top;

  localparam int DEPTH = 16;
  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [2:0]       cfg_pre_bytes = '0;
  logic [1:0]       cfg_sync_sel = '0;
  logic [63:0]      cfg_sync_word = 64'hD391_7A5C_0E6B_2F48;
  logic [3:0]       cfg_trl_bits = '0;
  logic [LEN_W-1:0] cfg_pay_len = '0;
  logic             cfg_crc_en = 1'b0;
  logic             wr_clr = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic             tx_bit;
  logic             tx_valid;
  logic             done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [7:0] mdl_mem [DEPTH];
  int         mdl_wp = 0;
  bit         exp_bits [4096];
  bit         got_bits [4096];
  int         exp_len;

  pkt_tx_framer #(.DEPTH(DEPTH), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_pre_bytes(cfg_pre_bytes), .cfg_sync_sel(cfg_sync_sel),
    .cfg_sync_word(cfg_sync_word), .cfg_trl_bits(cfg_trl_bits),
    .cfg_pay_len(cfg_pay_len), .cfg_crc_en(cfg_crc_en),
    .wr_clr(wr_clr), .wr_en(wr_en), .wr_data(wr_data),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .done(done)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic write_byte(input logic [7:0] d, input bit clr);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_clr = clr;
    if (clr) mdl_wp = 0;
    else begin mdl_mem[mdl_wp] = d; mdl_wp = (mdl_wp + 1) % DEPTH; end
    @(negedge clk);
    wr_en = 1'b0; wr_clr = 1'b0;
  endtask

  task automatic clear_wp();
    @(negedge clk);
    wr_clr = 1'b1; mdl_wp = 0;
    @(negedge clk);
    wr_clr = 1'b0;
  endtask

  // Reference frame from the requirements.
  task automatic build_exp();
    int n = 0;
    int pb = (int'(cfg_pre_bytes) + 1) * 8;
    int sl = (cfg_sync_sel == 2'd0) ? 32 : (cfg_sync_sel == 2'd1) ? 48 : 64;
    int tl = (cfg_trl_bits < 3) ? 4 : int'(cfg_trl_bits) + 1;
    bit s0 = cfg_sync_word[sl-1];
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < pb; k++) begin exp_bits[n] = s0 ^ bit'(k % 2); n++; end
    for (int k = 0; k < sl; k++) begin exp_bits[n] = cfg_sync_word[sl-1-k]; n++; end
    for (int j = 0; j < tl; j++) begin exp_bits[n] = !cfg_sync_word[0] ^ bit'(j % 2); n++; end
    for (int b = 0; b < int'(cfg_pay_len); b++) begin
      logic [7:0] by = mdl_mem[b % DEPTH];
      c = c ^ {by, 8'h00};
      for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      for (int i = 7; i >= 0; i--) begin exp_bits[n] = by[i]; n++; end
    end
    if (cfg_crc_en)
      for (int i = 15; i >= 0; i--) begin exp_bits[n] = c[i]; n++; end
    exp_len = n;
  endtask

  // Start a frame, capture it, compare with the model; inject_at >= 0 disturbs it mid-frame.
  task automatic run_frame(input string tag, input int inject_at);
    int n = 0;
    int bad = -1;
    logic [LEN_W-1:0] saved_len;
    build_exp();
    saved_len = cfg_pay_len;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(tx_valid == 1'b1, "R8 valid after start", int'(tx_valid), 1);
    while (tx_valid && n < 4000) begin
      got_bits[n] = tx_bit;
      if (n == inject_at) begin start = 1'b1; cfg_pay_len = saved_len + 3; cfg_crc_en = !cfg_crc_en; end
      if (n == inject_at + 1) begin start = 1'b0; cfg_pay_len = saved_len; cfg_crc_en = !cfg_crc_en; end
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    for (int i = 0; i < exp_len && i < n; i++) if (bad < 0 && got_bits[i] != exp_bits[i]) bad = i;
    check(n == exp_len, {tag, " length"}, n, exp_len);
    check(bad < 0, {tag, " first bad bit index"}, bad, -1);
    check(done == 1'b1, "R9 done after last bit", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0 && tx_valid == 1'b0, "R9 done one cycle / idle", int'({done, tx_valid}), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_valid == 1'b0 && done == 1'b0, "R1 reset outputs", int'({tx_valid, done}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_valid == 1'b0 && done == 1'b0, "R1 after reset", int'({tx_valid, done}), 0);

    for (int i = 0; i < DEPTH; i++) write_byte(8'(i * 37 + 11), 1'b0);

    cfg_pay_len = 8'd3;
    for (int p = 0; p < 8; p++) begin cfg_pre_bytes = 3'(p); run_frame("R2 preamble", -1); end
    cfg_pre_bytes = 3'd1;
    for (int s = 0; s < 4; s++) begin
      cfg_sync_sel = 2'(s);
      cfg_sync_word = (s % 2 == 1) ? 64'h2C6E_0B91_F4A3_5D17 : 64'hD391_7A5C_0E6B_2F48;
      run_frame("R3 sync", -1);
    end
    for (int t = 0; t < 16; t++) begin cfg_trl_bits = 4'(t); run_frame("R4 trailer", -1); end
    cfg_trl_bits = 4'd7;
    for (int l = 0; l < 21; l++) begin
      for (int e = 0; e < 2; e++) begin
        cfg_pay_len = 8'(l); cfg_crc_en = bit'(e);
        run_frame(e ? "R7 crc R12 wrap" : "R5 payload R12 wrap", -1);
      end
    end
    cfg_pay_len = 8'd5; cfg_crc_en = 1'b1;
    run_frame("R6 resend first", -1);
    run_frame("R6 resend again", -1);
    run_frame("R10 mid-frame start/cfg", 40);
    run_frame("R10 mid-payload start/cfg", 100);

    write_byte(8'hA5, 1'b1);
    write_byte(8'h11, 1'b0);
    write_byte(8'h22, 1'b0);
    clear_wp();
    write_byte(8'h5A, 1'b0);
    cfg_pay_len = 8'd3;
    run_frame("R11 write pointer clear", -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule